// File: doc/BRIEF.md
# Register-Mapped Hash Core Wrapper

This block places a narrow 32-bit register interface in front of a hash engine that has wide ports: a 512-bit message block input, a 160-bit digest output, and start, continue, ready and digest-valid signals. A host selects the block with a chip select, gives an 8-bit word address, and either writes 32-bit data or reads 32-bit data back in the same cycle. An error flag reports accesses that the register map does not allow.

The host fills sixteen block registers and starts the engine through a control word. One bit of that word starts a new message and the other continues an existing one. The host then polls a status word and reads the digest five words at a time. The engine reads the block from the wrapper's registers, so the host can load the next block while the engine still works on the current one. Three read-only words identify the block by name and version. The hash engine is not part of this block; the testbench plays its role.

Top module: `hash_regif`

## Requirements
- R1: After an asynchronous reset (rst_n low), all block registers read 0, core_block_o is 0, and core_init_o and core_next_o are low.
- R2: Reads of address 0x00 return 0x53484131, reads of 0x01 return 0x20202020, and reads of 0x02 return 0x302E3530, with err_o low.
- R3: A write to control address 0x08 drives core_init_o to wdata bit 0 and core_next_o to wdata bit 1 for exactly the one cycle after the write. Both are then low, and control reads as 0.
- R4: A read of status address 0x09 returns core_ready_i in bit 0 and core_digest_valid_i in bit 1, with all other bits 0.
- R5: A write to address 0x10+k (k = 0..15) stores block word k, and a read of that address returns it. Word k drives core_block_o bits [511-32k : 480-32k], so word 0 is the most significant.
- R6: A read of address 0x20+k (k = 0..4) returns core_digest_i bits [159-32k : 128-32k], so word 0 is the most significant.
- R7: Block writes take effect whatever core_ready_i and core_digest_valid_i are, including while the core is busy.
- R8: A write to any address other than 0x08 and 0x10..0x1F raises err_o in that cycle. It changes no block register and produces no pulse on core_init_o or core_next_o.
- R9: A read of any address outside 0x00..0x02, 0x08, 0x09, 0x10..0x1F and 0x20..0x24 raises err_o and returns 0.
- R10: rdata_o is combinational in the address. It is 0 during writes and whenever cs_i is low. err_o is low whenever cs_i is low and for every allowed access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Access select |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| err_o | output | 1 | Access error flag |
| core_init_o | output | 1 | One-cycle start pulse to the core |
| core_next_o | output | 1 | One-cycle continue pulse to the core |
| core_block_o | output | 512 | Message block to the core |
| core_ready_i | input | 1 | Core idle |
| core_digest_valid_i | input | 1 | Core digest valid |
| core_digest_i | input | 160 | Core digest |

## Verification
The bench uses the default parameters: 32-bit words, an 8-bit address, 16 block words and 5 digest words. At that size the address space has only 256 words, so the bench reads every address under all four combinations of ready and valid. It also writes every address once and computes the expected error, data and pulse for each from the address arithmetic. Each bit of the control word is exercised alone and together with the other.

// File: rtl/hash_regif_pkg.sv
package hash_regif_pkg;

    typedef enum logic [2:0] {
        RG_NAME0,
        RG_NAME1,
        RG_VER,
        RG_CTRL,
        RG_STAT,
        RG_BLOCK,
        RG_DIGEST,
        RG_NONE
    } region_e;

    localparam int unsigned ADR_NAME0  = 32'h00;
    localparam int unsigned ADR_NAME1  = 32'h01;
    localparam int unsigned ADR_VER    = 32'h02;
    localparam int unsigned ADR_CTRL   = 32'h08;
    localparam int unsigned ADR_STAT   = 32'h09;
    localparam int unsigned ADR_BLOCK  = 32'h10;
    localparam int unsigned ADR_DIGEST = 32'h20;

    localparam logic [31:0] ID_NAME0 = 32'h53484131;
    localparam logic [31:0] ID_NAME1 = 32'h20202020;
    localparam logic [31:0] ID_VER   = 32'h302E3530;

endpackage

// File: rtl/hash_regif_decode.sv
module hash_regif_decode
    import hash_regif_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int BLOCK_WORDS  = 16,
    parameter int DIGEST_WORDS = 5,
    parameter int IDX_W        = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output region_e           region_o,
    output logic [IDX_W-1:0]  idx_o
);

    int unsigned a;

    always_comb begin
        a        = {{(32-ADDR_W){1'b0}}, addr_i};
        region_o = RG_NONE;
        idx_o    = '0;
        if (a == ADR_NAME0) begin
            region_o = RG_NAME0;
        end else if (a == ADR_NAME1) begin
            region_o = RG_NAME1;
        end else if (a == ADR_VER) begin
            region_o = RG_VER;
        end else if (a == ADR_CTRL) begin
            region_o = RG_CTRL;
        end else if (a == ADR_STAT) begin
            region_o = RG_STAT;
        end else if (a >= ADR_BLOCK && a < ADR_BLOCK + BLOCK_WORDS) begin
            region_o = RG_BLOCK;
            idx_o    = IDX_W'(a - ADR_BLOCK);
        end else if (a >= ADR_DIGEST && a < ADR_DIGEST + DIGEST_WORDS) begin
            region_o = RG_DIGEST;
            idx_o    = IDX_W'(a - ADR_DIGEST);
        end
    end

endmodule

// File: rtl/hash_regif_blockbank.sv
module hash_regif_blockbank #(
    parameter int DW    = 32,
    parameter int WORDS = 16,
    parameter int IDX_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [IDX_W-1:0]           wr_idx_i,
    input  logic [DW-1:0]              wr_data_i,
    output logic [WORDS-1:0][DW-1:0]   words_o,
    output logic [WORDS*DW-1:0]        flat_o
);

    typedef struct packed {
        logic [WORDS-1:0][DW-1:0] w;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i && int'(wr_idx_i) < WORDS) begin
            bank_d.w[wr_idx_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign words_o = bank_q.w;

    // word 0 sits at the most significant end of the flat vector
    for (genvar g = 0; g < WORDS; g++) begin : g_flat
        assign flat_o[(WORDS-1-g)*DW +: DW] = bank_q.w[g];
    end

    // R8
    block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(bank_q));

    // R5
    block_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> words_o[$past(wr_idx_i)] == $past(wr_data_i));

endmodule

// File: rtl/hash_regif_rdmux.sv
module hash_regif_rdmux
    import hash_regif_pkg::*;
#(
    parameter int DW           = 32,
    parameter int BLOCK_WORDS  = 16,
    parameter int DIGEST_WORDS = 5,
    parameter int IDX_W        = 4
) (
    input  region_e                         region_i,
    input  logic [IDX_W-1:0]                idx_i,
    input  logic [BLOCK_WORDS-1:0][DW-1:0]  blocks_i,
    input  logic [DIGEST_WORDS-1:0][DW-1:0] digest_i,
    input  logic                            ready_i,
    input  logic                            valid_i,
    input  logic                            init_i,
    input  logic                            next_i,
    output logic [DW-1:0]                   data_o
);

    always_comb begin
        data_o = '0;
        unique case (region_i)
            RG_NAME0: data_o = DW'(ID_NAME0);
            RG_NAME1: data_o = DW'(ID_NAME1);
            RG_VER:   data_o = DW'(ID_VER);
            RG_CTRL:  data_o = DW'({next_i, init_i});
            RG_STAT:  data_o = DW'({valid_i, ready_i});
            RG_BLOCK: begin
                if (int'(idx_i) < BLOCK_WORDS) data_o = blocks_i[idx_i];
            end
            RG_DIGEST: begin
                if (int'(idx_i) < DIGEST_WORDS) data_o = digest_i[idx_i];
            end
            default:  data_o = '0;
        endcase
    end

endmodule

// File: rtl/hash_regif.sv
module hash_regif
    import hash_regif_pkg::*;
#(
    parameter int DW           = 32,
    parameter int ADDR_W       = 8,
    parameter int BLOCK_WORDS  = 16,
    parameter int DIGEST_WORDS = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_i,
    input  logic                         we_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [DW-1:0]                wdata_i,
    output logic [DW-1:0]                rdata_o,
    output logic                         err_o,
    output logic                         core_init_o,
    output logic                         core_next_o,
    output logic [BLOCK_WORDS*DW-1:0]    core_block_o,
    input  logic                         core_ready_i,
    input  logic                         core_digest_valid_i,
    input  logic [DIGEST_WORDS*DW-1:0]   core_digest_i
);

    localparam int MAX_WORDS = (BLOCK_WORDS > DIGEST_WORDS) ? BLOCK_WORDS : DIGEST_WORDS;
    localparam int IDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

    typedef struct packed {
        logic init;
        logic next;
    } cmd_t;

    region_e                         region;
    logic [IDX_W-1:0]                idx;
    logic [BLOCK_WORDS-1:0][DW-1:0]  blk_words;
    logic [DIGEST_WORDS-1:0][DW-1:0] dig_words;
    logic [DW-1:0]                   mux_data;
    logic                            wr_ok, wr_blk, wr_ctl, rd_acc;
    cmd_t                            cmd_d, cmd_q;

    hash_regif_decode #(
        .ADDR_W       (ADDR_W),
        .BLOCK_WORDS  (BLOCK_WORDS),
        .DIGEST_WORDS (DIGEST_WORDS),
        .IDX_W        (IDX_W)
    ) u_decode (
        .addr_i   (addr_i),
        .region_o (region),
        .idx_o    (idx)
    );

    assign wr_blk = cs_i && we_i && region == RG_BLOCK;
    assign wr_ctl = cs_i && we_i && region == RG_CTRL;
    assign wr_ok  = wr_blk || wr_ctl;
    assign rd_acc = cs_i && !we_i;

    hash_regif_blockbank #(
        .DW    (DW),
        .WORDS (BLOCK_WORDS),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_blk),
        .wr_idx_i  (idx),
        .wr_data_i (wdata_i),
        .words_o   (blk_words),
        .flat_o    (core_block_o)
    );

    for (genvar g = 0; g < DIGEST_WORDS; g++) begin : g_dig
        assign dig_words[g] = core_digest_i[(DIGEST_WORDS-1-g)*DW +: DW];
    end

    hash_regif_rdmux #(
        .DW           (DW),
        .BLOCK_WORDS  (BLOCK_WORDS),
        .DIGEST_WORDS (DIGEST_WORDS),
        .IDX_W        (IDX_W)
    ) u_rdmux (
        .region_i (region),
        .idx_i    (idx),
        .blocks_i (blk_words),
        .digest_i (dig_words),
        .ready_i  (core_ready_i),
        .valid_i  (core_digest_valid_i),
        .init_i   (cmd_q.init),
        .next_i   (cmd_q.next),
        .data_o   (mux_data)
    );

    // command bits live for one cycle only
    always_comb begin
        cmd_d = '0;
        if (wr_ctl) begin
            cmd_d.init = wdata_i[0];
            cmd_d.next = wdata_i[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign core_init_o = cmd_q.init;
    assign core_next_o = cmd_q.next;

    assign rdata_o = rd_acc ? mux_data : '0;
    assign err_o   = cs_i && ((we_i && !wr_ok) || (!we_i && region == RG_NONE));

    // R3
    init_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_init_o |-> $past(cs_i && we_i && region == RG_CTRL && wdata_i[0]));

    // R3
    next_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_next_o |-> $past(cs_i && we_i && region == RG_CTRL && wdata_i[1]));

    // R9
    err_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && err_o) |-> rdata_o == '0);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |-> (rdata_o == '0 && !err_o));

endmodule

// File: tb/hash_regif_tb.sv
module hash_regif_tb;

    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_i = 1'b0;
    logic         we_i = 1'b0;
    logic [7:0]   addr_i = '0;
    logic [31:0]  wdata_i = '0;
    logic [31:0]  rdata_o;
    logic         err_o;
    logic         core_init_o;
    logic         core_next_o;
    logic [511:0] core_block_o;
    logic         core_ready_i = 1'b1;
    logic         core_digest_valid_i = 1'b0;
    logic [159:0] core_digest_i = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] blk_m [16];

    always #(CLK_NS/2) clk = ~clk;

    hash_regif u_dut (
        .clk                 (clk),
        .rst_n               (rst_n),
        .cs_i                (cs_i),
        .we_i                (we_i),
        .addr_i              (addr_i),
        .wdata_i             (wdata_i),
        .rdata_o             (rdata_o),
        .err_o               (err_o),
        .core_init_o         (core_init_o),
        .core_next_o         (core_next_o),
        .core_block_o        (core_block_o),
        .core_ready_i        (core_ready_i),
        .core_digest_valid_i (core_digest_valid_i),
        .core_digest_i       (core_digest_i)
    );

    function automatic logic [31:0] dig_word(int k);
        return 32'hD00D0000 + 32'(k) * 32'h01010101;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // expected read result computed from the register map
    task automatic exp_read(input int a, output bit e, output logic [31:0] d);
        e = 1'b0;
        d = '0;
        if (a == 0)                 d = 32'h53484131;
        else if (a == 1)            d = 32'h20202020;
        else if (a == 2)            d = 32'h302E3530;
        else if (a == 8)            d = '0;
        else if (a == 9)            d = {30'b0, core_digest_valid_i, core_ready_i};
        else if (a >= 16 && a < 32) d = blk_m[a-16];
        else if (a >= 32 && a < 37) d = dig_word(a-32);
        else                        e = 1'b1;
    endtask

    task automatic do_read(input int a, output logic [31:0] d, output bit e);
        @(negedge clk);
        cs_i = 1'b1; we_i = 1'b0; addr_i = 8'(a);
        #1;
        d = rdata_o; e = err_o;
        cs_i = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [31:0] wd, output bit e,
                            output logic [31:0] rd, output bit pi, output bit pn,
                            output bit ai, output bit an);
        @(negedge clk);
        cs_i = 1'b1; we_i = 1'b1; addr_i = 8'(a); wdata_i = wd;
        #1;
        e = err_o; rd = rdata_o;
        @(posedge clk); #1;
        cs_i = 1'b0; we_i = 1'b0;
        pi = core_init_o; pn = core_next_o;
        @(posedge clk); #1;
        ai = core_init_o; an = core_next_o;
    endtask

    task automatic check_block_port(input string req);
        for (int k = 0; k < 16; k++) begin
            chk(core_block_o[511-32*k -: 32] == blk_m[k], req,
                core_block_o[511-32*k -: 32], blk_m[k]);
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, rd;
        bit e, pi, pn, ai, an, ee;
        logic [31:0] ed;

        for (int k = 0; k < 16; k++) blk_m[k] = '0;
        for (int k = 0; k < 5; k++) core_digest_i[159-32*k -: 32] = dig_word(k);

        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(core_block_o == '0, "R1 block port", core_block_o[31:0], 32'd0);
        chk(!core_init_o && !core_next_o, "R1 pulses", {30'b0, core_next_o, core_init_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 idle bus
        @(negedge clk); #1;
        chk(rdata_o == '0 && !err_o, "R10 idle", rdata_o, 32'd0);

        // R1/R2/R4/R6/R9/R10: read sweep under every ready/valid pair
        for (int rv = 0; rv < 4; rv++) begin
            core_ready_i        = rv[0];
            core_digest_valid_i = rv[1];
            for (int a = 0; a < 256; a++) begin
                do_read(a, d, e);
                exp_read(a, ee, ed);
                chk(d == ed, "R2 R4 R6 R1 read data", d, ed);
                chk(e == ee, "R9 R10 read error", 32'(e), 32'(ee));
            end
        end

        // R3 each control bit alone and together
        for (int c = 0; c < 4; c++) begin
            do_write(8, 32'hFFFF_FFF0 | 32'(c), e, rd, pi, pn, ai, an);
            chk(!e, "R10 ctrl write err", 32'(e), 32'd0);
            chk({pn, pi} == 2'(c), "R3 pulse", {30'b0, pn, pi}, 32'(c));
            chk({an, ai} == 2'b00, "R3 self clear", {30'b0, an, ai}, 32'd0);
            do_read(8, d, e);
            chk(d == '0, "R3 ctrl reads 0", d, 32'd0);
        end

        // R5/R8/R10: write sweep over every address, core idle
        core_ready_i = 1'b1;
        core_digest_valid_i = 1'b0;
        for (int a = 0; a < 256; a++) begin
            logic [31:0] wd;
            bit writable;
            wd = {8'(a), 8'(a) ^ 8'hC3, 8'h3C, 8'(a) ^ 8'h96};
            writable = (a == 8) || (a >= 16 && a < 32);
            do_write(a, wd, e, rd, pi, pn, ai, an);
            chk(e == !writable, "R8 write error", 32'(e), 32'(!writable));
            chk(rd == '0, "R10 rdata during write", rd, 32'd0);
            if (a == 8) begin
                chk({pn, pi} == wd[1:0], "R3 sweep pulse", {30'b0, pn, pi}, {30'b0, wd[1:0]});
            end else begin
                chk({pn, pi} == 2'b00, "R8 no pulse", {30'b0, pn, pi}, 32'd0);
            end
            if (a >= 16 && a < 32) blk_m[a-16] = wd;
        end
        check_block_port("R5 R8 block port");
        for (int k = 0; k < 16; k++) begin
            do_read(16 + k, d, e);
            chk(d == blk_m[k] && !e, "R5 block readback", d, blk_m[k]);
        end

        // R7: reload while the core reports busy
        core_ready_i = 1'b0;
        core_digest_valid_i = 1'b0;
        for (int k = 0; k < 16; k++) begin
            logic [31:0] wd;
            wd = 32'hA5000000 ^ (32'(k) * 32'h00010203);
            do_write(16 + k, wd, e, rd, pi, pn, ai, an);
            chk(!e, "R7 busy write err", 32'(e), 32'd0);
            blk_m[k] = wd;
        end
        check_block_port("R7 block port busy");
        for (int k = 0; k < 16; k++) begin
            do_read(16 + k, d, e);
            chk(d == blk_m[k], "R7 busy readback", d, blk_m[k]);
        end

        // R6 with a different digest value
        for (int k = 0; k < 5; k++) core_digest_i[159-32*k -: 32] = ~dig_word(k);
        for (int k = 0; k < 5; k++) begin
            do_read(32 + k, d, e);
            chk(d == ~dig_word(k) && !e, "R6 digest order", d, ~dig_word(k));
        end

        // R1 asynchronous reset clears block contents mid-cycle
        @(negedge clk); #2;
        rst_n = 1'b0;
        #1;
        chk(core_block_o == '0, "R1 async clear", core_block_o[511:480], 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule